// File: doc/BRIEF.md
# Configuration Access Sequencer Bridge

This block turns byte, halfword and word configuration requests from a host into 32-bit-only cycles on a downstream bridge. The bridge is reached through two registers: an address register at offset 0x500 and a data register at offset 0x504. A request carries a bus number, a device/function number, a register offset, a size and, for writes, data. The sequencer always writes the address register first. It then reads or writes the data register.

A sub-word read fetches the whole dword and returns the selected lane, zero-extended. A sub-word write fetches the dword, replaces the selected lane and writes the full dword back. The downstream data is big-endian, so lanes are steered by XOR on the low offset bits. Targets outside the supported range never reach the bus. Phases that get no acknowledge are cut off by a programmable timeout. In both of these cases the response is all ones at the requested width, and a timeout also sets a sticky error flag.

Top module: `cfg_seq_bridge`

## Requirements
- R1: An accepted in-range request first writes the address register (dn_addr 0x500) with bus in bits 23:16, device/function in bits 15:8, offset bits 7:2 in bits 7:2 and bit 1 zero. Every following phase uses the data register (dn_addr 0x504).
- R2: Bit 0 of the address word is 1 when the bus number is nonzero (type 1) and 0 for bus 0 (type 0).
- R3: A request with bus above 7 or device/function above 127 drives no downstream phase. Its response comes in the cycle after acceptance with status 1 and data 0xFF, 0xFFFF or 0xFFFFFFFF for size codes 0 (byte), 1 (halfword) and 2 or 3 (word).
- R4: Every read issues exactly one dword read. A byte result is dword bits [8k+7:8k] with k = offset mod 4, which is lane (offset XOR 3) counted from the most significant byte. A halfword result is bits [16h+15:16h] with h = offset bit 1. Both are zero-extended.
- R5: A byte or halfword write runs three phases in order: address write, data read, then data write of the read dword with only the R4 lane(s) replaced by the low bits of the write data.
- R6: A word write runs an address write followed directly by a data write of the request data, with no read phase.
- R7: A phase that sees no acknowledge for the timeout limit of consecutive cycles ends at that edge. No further phase follows, and the response carries status 1 and the R3 all-ones value for the request size.
- R8: The timeout limit is 256 after reset. A tmo_load pulse replaces it with tmo_value.
- R9: err_sticky rises with a timeout, stays high through later requests, and clears after an err_clr pulse. A timeout in the same cycle as err_clr wins.
- R10: req_ready is high only while idle. busy is high from the cycle after acceptance through the response cycle. rsp_valid is a single-cycle pulse in the cycle after the final acknowledge.
- R11: A completed access returns status 0. A completed write returns data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_bus | input | 8 | Bus number |
| req_devfn | input | 8 | Device/function number |
| req_offset | input | 8 | Register offset in bytes |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 32 | Zero-extended read data |
| rsp_status | output | 1 | 0 success, 1 not found or timeout |
| busy | output | 1 | Request in progress |
| dn_req | output | 1 | Downstream phase active |
| dn_we | output | 1 | Downstream phase is a write |
| dn_addr | output | 12 | Downstream register offset |
| dn_wdata | output | 32 | Downstream write data |
| dn_rdata | input | 32 | Downstream read data, valid with ack |
| dn_ack | input | 1 | Downstream phase acknowledge |
| tmo_load | input | 1 | Load a new timeout limit |
| tmo_value | input | 16 | New timeout limit |
| err_clr | input | 1 | Write-one-to-clear pulse for err_sticky |
| err_sticky | output | 1 | Sticky timeout flag |

## Verification
Each downstream phase starts in the cycle after the edge that accepted the request or acknowledged the previous phase. The response pulse follows one cycle after the last acknowledge, or one cycle after acceptance for an out-of-range target. A timed-out phase ends exactly limit edges after it started.

The bench keeps a behavioural model that advances on each rising edge from the bench-driven inputs alone. Every falling edge it compares busy, ready, the phase address, direction and data, the response and the sticky flag. Acknowledge latency is varied, so a design that is off by one cycle anywhere shows up as a mismatch.

// File: rtl/cfgsq_pkg.sv
package cfgsq_pkg;
  localparam int CFG_DW = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } acc_size_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_RD   = 3'd2,
    ST_WR   = 3'd3,
    ST_RSP  = 3'd4
  } seq_state_e;

  typedef struct packed {
    logic              write;
    acc_size_e         size;
    logic [7:0]        bus;
    logic [7:0]        devfn;
    logic [7:0]        offset;
    logic [CFG_DW-1:0] wdata;
  } cfg_req_t;

  function automatic logic [CFG_DW-1:0] size_ones(acc_size_e s);
    case (s)
      SZ_BYTE: return CFG_DW'(32'h0000_00FF);
      SZ_HALF: return CFG_DW'(32'h0000_FFFF);
      default: return '1;
    endcase
  endfunction

  function automatic logic is_word(acc_size_e s);
    return s[1];
  endfunction
endpackage

// File: rtl/cfgsq_rst_sync.sv
module cfgsq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/cfgsq_addr_gen.sv
module cfgsq_addr_gen #(
  parameter int MAX_BUS   = 7,
  parameter int MAX_DEVFN = 127
) (
  input  logic [7:0]  bus,
  input  logic [7:0]  devfn,
  input  logic [7:0]  offset,
  output logic [31:0] cfg_word,
  output logic        in_range
);
  localparam logic [7:0] BUS_LIM   = 8'(MAX_BUS);
  localparam logic [7:0] DEVFN_LIM = 8'(MAX_DEVFN);

  always_comb begin
    cfg_word        = '0;
    cfg_word[23:16] = bus;
    cfg_word[15:8]  = devfn;
    cfg_word[7:2]   = offset[7:2];
    cfg_word[0]     = (bus != 8'd0);   // type 1 for buses behind a bridge (R2)
  end

  assign in_range = (bus <= BUS_LIM) && (devfn <= DEVFN_LIM);
endmodule

// File: rtl/cfgsq_lane.sv
module cfgsq_lane
  import cfgsq_pkg::*;
(
  input  logic [CFG_DW-1:0] dword,
  input  acc_size_e         size,
  input  logic [1:0]        off,
  input  logic [CFG_DW-1:0] wdata,
  output logic [CFG_DW-1:0] rd_ext,
  output logic [CFG_DW-1:0] merged
);
  localparam int LANES = CFG_DW / 8;

  logic [1:0] byte_from_msb;
  logic       half_from_msb;
  logic [1:0] byte_idx;
  logic       half_idx;

  // big-endian lane steering: index counted from the top byte
  assign byte_from_msb = off ^ 2'b11;
  assign half_from_msb = off[1] ^ 1'b1;
  assign byte_idx      = 2'd3 - byte_from_msb;
  assign half_idx      = ~half_from_msb;

  always_comb begin
    case (size)
      SZ_BYTE: rd_ext = {24'd0, dword[{byte_idx, 3'b000} +: 8]};
      SZ_HALF: rd_ext = {16'd0, dword[{half_idx, 4'b0000} +: 16]};
      default: rd_ext = dword;
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic       hit;
    logic [7:0] src;
    assign hit = ((size == SZ_BYTE) && (byte_idx == 2'(g))) ||
                 ((size == SZ_HALF) && (half_idx == 1'(g / 2)));
    assign src = (size == SZ_HALF) ? wdata[8*(g%2) +: 8] : wdata[7:0];
    assign merged[8*g +: 8] = hit ? src : dword[8*g +: 8];
  end
endmodule

// File: rtl/cfgsq_tmo.sv
module cfgsq_tmo #(
  parameter int TMO_W     = 16,
  parameter int TMO_RESET = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase_active,
  input  logic             ack,
  input  logic             load,
  input  logic [TMO_W-1:0] load_val,
  output logic             expire
);
  localparam logic [TMO_W-1:0] LIM_RST = TMO_W'(TMO_RESET);

  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic [TMO_W-1:0] lim_q;
  logic             cnt_en;

  assign expire = phase_active && !ack && (cnt_q >= (lim_q - 1'b1));
  assign cnt_en = 1'b1;

  always_comb begin
    if (!phase_active || ack || expire) cnt_d = '0;
    else                                cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lim_q <= LIM_RST;   // R8
    else if (load) lim_q <= load_val;
  end
endmodule

// File: rtl/cfg_seq_bridge.sv
module cfg_seq_bridge
  import cfgsq_pkg::*;
#(
  parameter int              MAX_BUS   = 7,
  parameter int              MAX_DEVFN = 127,
  parameter int              TMO_W     = 16,
  parameter int              TMO_RESET = 256,
  parameter int              REG_AW    = 12,
  parameter logic [REG_AW-1:0] ADDR_OFS = 12'h500,
  parameter logic [REG_AW-1:0] DATA_OFS = 12'h504
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [7:0]        req_bus,
  input  logic [7:0]        req_devfn,
  input  logic [7:0]        req_offset,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_status,
  output logic              busy,
  output logic              dn_req,
  output logic              dn_we,
  output logic [REG_AW-1:0] dn_addr,
  output logic [31:0]       dn_wdata,
  input  logic [31:0]       dn_rdata,
  input  logic              dn_ack,
  input  logic              tmo_load,
  input  logic [TMO_W-1:0]  tmo_value,
  input  logic              err_clr,
  output logic              err_sticky
);
  logic        rst_sn;
  seq_state_e  st_q, st_d;
  cfg_req_t    req_q, req_d;
  logic [31:0] word_q, word_d;
  logic [31:0] wr_q, wr_d;
  logic [31:0] rdat_q, rdat_d;
  logic        stat_q, stat_d;
  logic        err_q, err_d;
  logic        accept, ld_req, ld_wr, ld_rsp;
  logic [31:0] cfg_word, rd_ext, merged;
  logic        in_range, expire;

  cfgsq_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_sn)
  );

  cfgsq_addr_gen #(.MAX_BUS(MAX_BUS), .MAX_DEVFN(MAX_DEVFN)) i_addr_gen (
    .bus(req_bus), .devfn(req_devfn), .offset(req_offset),
    .cfg_word(cfg_word), .in_range(in_range)
  );

  cfgsq_lane i_lane (
    .dword(dn_rdata), .size(req_q.size), .off(req_q.offset[1:0]),
    .wdata(req_q.wdata), .rd_ext(rd_ext), .merged(merged)
  );

  cfgsq_tmo #(.TMO_W(TMO_W), .TMO_RESET(TMO_RESET)) i_tmo (
    .clk(clk), .rst_n(rst_sn), .phase_active(dn_req), .ack(dn_ack),
    .load(tmo_load), .load_val(tmo_value), .expire(expire)
  );

  assign accept = req_valid && (st_q == ST_IDLE);

  // next-state and datapath selection
  always_comb begin
    st_d   = st_q;
    req_d  = '{write: req_write, size: acc_size_e'(req_size), bus: req_bus,
               devfn: req_devfn, offset: req_offset, wdata: req_wdata};
    word_d = cfg_word;
    wr_d   = (st_q == ST_RD) ? merged : req_wdata;
    rdat_d = size_ones(req_q.size);
    stat_d = 1'b1;
    ld_req = 1'b0;
    ld_wr  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          ld_req = 1'b1;
          ld_wr  = 1'b1;
          if (!in_range) begin
            st_d   = ST_RSP;
            rdat_d = size_ones(acc_size_e'(req_size));
          end else begin
            st_d = ST_ADDR;
          end
        end
      end
      ST_ADDR: begin
        if (dn_ack)      st_d = (req_q.write && is_word(req_q.size)) ? ST_WR : ST_RD;
        else if (expire) st_d = ST_RSP;
      end
      ST_RD: begin
        if (dn_ack) begin
          if (req_q.write) begin
            ld_wr = 1'b1;
            st_d  = ST_WR;
          end else begin
            rdat_d = rd_ext;
            stat_d = 1'b0;
            st_d   = ST_RSP;
          end
        end else if (expire) begin
          st_d = ST_RSP;
        end
      end
      ST_WR: begin
        if (dn_ack) begin
          rdat_d = '0;
          stat_d = 1'b0;
          st_d   = ST_RSP;
        end else if (expire) begin
          st_d = ST_RSP;
        end
      end
      ST_RSP:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    ld_rsp = (st_d == ST_RSP) && (st_q != ST_RSP);
    err_d  = expire | (err_q & ~err_clr);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      req_q  <= '0;
      word_q <= '0;
    end else if (ld_req) begin
      req_q  <= req_d;
      word_q <= word_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)    wr_q <= '0;
    else if (ld_wr) wr_q <= wr_d;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      rdat_q <= '0;
      stat_q <= 1'b0;
    end else if (ld_rsp) begin
      rdat_q <= rdat_d;
      stat_q <= stat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) err_q <= 1'b0;
    else         err_q <= err_d;
  end

  assign req_ready  = (st_q == ST_IDLE);
  assign busy       = (st_q != ST_IDLE);
  assign rsp_valid  = (st_q == ST_RSP);
  assign rsp_rdata  = rdat_q;
  assign rsp_status = stat_q;
  assign err_sticky = err_q;
  assign dn_req     = (st_q == ST_ADDR) || (st_q == ST_RD) || (st_q == ST_WR);
  assign dn_we      = (st_q == ST_ADDR) || (st_q == ST_WR);
  assign dn_addr    = (st_q == ST_ADDR) ? ADDR_OFS : DATA_OFS;
  assign dn_wdata   = (st_q == ST_ADDR) ? word_q : ((st_q == ST_WR) ? wr_q : '0);

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_sn)
    rsp_valid |=> !rsp_valid);                                             // R10
  AST_START_AT_ADDR: assert property (@(posedge clk) disable iff (!rst_sn)
    (dn_req && !$past(dn_req)) |-> (dn_we && dn_addr == ADDR_OFS));        // R1
  AST_TYPE_BIT: assert property (@(posedge clk) disable iff (!rst_sn)
    (dn_req && dn_we && dn_addr == ADDR_OFS) |->
      (dn_wdata[0] == (dn_wdata[23:16] != 8'd0)));                         // R2
  AST_OOR_SILENT: assert property (@(posedge clk) disable iff (!rst_sn)
    (accept && !in_range) |=> (!dn_req && rsp_valid && rsp_status));      // R3
  AST_WORD_WR_NO_READ: assert property (@(posedge clk) disable iff (!rst_sn)
    (dn_req && !dn_we && req_q.write) |-> !is_word(req_q.size));          // R6
  AST_TMO_FAILS: assert property (@(posedge clk) disable iff (!rst_sn)
    expire |=> (rsp_valid && rsp_status && err_sticky));                  // R7
endmodule

// File: tb/test_cfg_seq_bridge.sv
`timescale 1ns/1ps
module test_cfg_seq_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [7:0]  req_bus = '0, req_devfn = '0, req_offset = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_status, busy;
  logic        dn_req, dn_we;
  logic [11:0] dn_addr;
  logic [31:0] dn_wdata;
  logic [31:0] dn_rdata = '0;
  logic        dn_ack = 1'b0;
  logic        tmo_load = 1'b0;
  logic [15:0] tmo_value = '0;
  logic        err_clr = 1'b0;
  logic        err_sticky;
  logic [31:0] rsp_rdata;

  int total = 0, bad = 0, cyc = 0;
  bit run = 1'b0;

  always #5 clk = ~clk;

  cfg_seq_bridge i_cfg_seq_bridge (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_bus(req_bus),
    .req_devfn(req_devfn), .req_offset(req_offset), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_status(rsp_status),
    .busy(busy), .dn_req(dn_req), .dn_we(dn_we), .dn_addr(dn_addr),
    .dn_wdata(dn_wdata), .dn_rdata(dn_rdata), .dn_ack(dn_ack),
    .tmo_load(tmo_load), .tmo_value(tmo_value), .err_clr(err_clr),
    .err_sticky(err_sticky)
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  // ---------------- downstream target model ----------------
  logic [31:0] mem [logic [31:0]];
  logic [31:0] s_addr = '0;
  int s_cnt = 0, s_lat = 1;

  function automatic logic [31:0] mem_rd(logic [31:0] key);
    if (mem.exists(key)) return mem[key];
    return key ^ 32'hA5C3_0F1E;
  endfunction

  always @(negedge clk) begin
    if (dn_ack) begin
      dn_ack = 1'b0;
      s_cnt  = 0;
    end else if (dn_req) begin
      if (s_cnt >= s_lat && !(dn_addr == 12'h504 && s_addr[15:8] == 8'h7E)) begin
        dn_ack = 1'b1;
        if (dn_we && dn_addr == 12'h500) s_addr = dn_wdata;
        else if (dn_we)                  mem[s_addr] = dn_wdata;
        else                             dn_rdata = mem_rd(s_addr);
      end else begin
        s_cnt++;
      end
    end
  end

  // ---------------- behavioural reference ----------------
  function automatic logic [31:0] m_ones(int sz);
    if (sz == 0) return 32'hFF;
    if (sz == 1) return 32'hFFFF;
    return 32'hFFFF_FFFF;
  endfunction
  function automatic logic [31:0] m_extract(logic [31:0] d, int sz, int off);
    if (sz == 0) return (d >> (8 * (off % 4))) & 32'hFF;
    if (sz == 1) return (d >> (16 * ((off / 2) % 2))) & 32'hFFFF;
    return d;
  endfunction
  function automatic logic [31:0] m_merge(logic [31:0] d, int sz, int off, logic [31:0] w);
    int sh;
    if (sz == 0) begin
      sh = 8 * (off % 4);
      return (d & ~(32'hFF << sh)) | ((w & 32'hFF) << sh);
    end
    sh = 16 * ((off / 2) % 2);
    return (d & ~(32'hFFFF << sh)) | ((w & 32'hFFFF) << sh);
  endfunction

  int          m_state = 0, m_cnt = 0, m_lim = 256, m_sz = 0;
  logic        m_err = 1'b0, m_stat = 1'b0, m_abort;
  logic [31:0] m_rdat = '0, m_word;
  string       m_tag = "R10";
  logic        q_we[$];
  logic [11:0] q_addr[$];
  logic [31:0] q_wd[$];
  string       q_tag[$];

  always @(posedge clk) begin
    if (run) begin
      m_abort = 1'b0;
      case (m_state)
        0: if (req_valid) begin
          m_sz = (req_size >= 2) ? 2 : int'(req_size);
          if (req_bus > 7 || req_devfn > 127) begin
            m_state = 2; m_rdat = m_ones(m_sz); m_stat = 1'b1; m_tag = "R3";
          end else begin
            m_word = (32'(req_bus) << 16) | (32'(req_devfn) << 8) |
                     (32'(req_offset) & 32'hFC) | ((req_bus != 0) ? 32'd1 : 32'd0);
            q_we.push_back(1'b1); q_addr.push_back(12'h500);
            q_wd.push_back(m_word); q_tag.push_back("R1,R2");
            if (req_write && m_sz == 2) begin
              q_we.push_back(1'b1); q_addr.push_back(12'h504);
              q_wd.push_back(req_wdata); q_tag.push_back("R6");
              m_rdat = 32'd0; m_tag = "R11";
            end else begin
              q_we.push_back(1'b0); q_addr.push_back(12'h504);
              q_wd.push_back(32'd0); q_tag.push_back(req_write ? "R5" : "R4");
              if (req_write) begin
                q_we.push_back(1'b1); q_addr.push_back(12'h504);
                q_wd.push_back(m_merge(mem_rd(m_word), m_sz, int'(req_offset), req_wdata));
                q_tag.push_back("R5");
                m_rdat = 32'd0; m_tag = "R11";
              end else begin
                m_rdat = m_extract(mem_rd(m_word), m_sz, int'(req_offset));
                m_tag = "R4,R11";
              end
            end
            m_stat = 1'b0; m_state = 1; m_cnt = 0;
          end
        end
        1: begin
          if (dn_ack) begin
            void'(q_we.pop_front()); void'(q_addr.pop_front());
            void'(q_wd.pop_front()); void'(q_tag.pop_front());
            m_cnt = 0;
            if (q_we.size() == 0) m_state = 2;
          end else begin
            m_cnt++;
            if (m_cnt == m_lim) begin
              m_abort = 1'b1;
              q_we.delete(); q_addr.delete(); q_wd.delete(); q_tag.delete();
              m_state = 2; m_rdat = m_ones(m_sz); m_stat = 1'b1;
              m_tag = (m_lim == 256) ? "R7,R8" : "R7";
            end
          end
        end
        default: m_state = 0;
      endcase
      if (m_abort)      m_err = 1'b1;
      else if (err_clr) m_err = 1'b0;
      if (tmo_load) m_lim = int'(tmo_value);
    end
  end

  always @(negedge clk) begin
    if (run) begin
      chk(busy == (m_state != 0), "R10 busy", 32'(busy), 32'(m_state != 0));
      chk(req_ready == (m_state == 0), "R10 ready", 32'(req_ready), 32'(m_state == 0));
      chk(rsp_valid == (m_state == 2), (m_state == 2) ? m_tag : "R10",
          32'(rsp_valid), 32'(m_state == 2));
      chk(dn_req == (m_state == 1), (m_state == 1) ? q_tag[0] : "R3 idle bus",
          32'(dn_req), 32'(m_state == 1));
      if (m_state == 1 && q_we.size() > 0) begin
        chk(dn_we == q_we[0], q_tag[0], 32'(dn_we), 32'(q_we[0]));
        chk(dn_addr == q_addr[0], q_tag[0], 32'(dn_addr), 32'(q_addr[0]));
        if (q_we[0]) chk(dn_wdata == q_wd[0], q_tag[0], dn_wdata, q_wd[0]);
      end
      if (m_state == 2) begin
        chk(rsp_rdata == m_rdat, m_tag, rsp_rdata, m_rdat);
        chk(rsp_status == m_stat, m_tag, 32'(rsp_status), 32'(m_stat));
      end
      chk(err_sticky == m_err, "R9", 32'(err_sticky), 32'(m_err));
    end
  end

  // ---------------- stimulus ----------------
  task automatic do_req(bit w, int sz, int bus, int devfn, int off, logic [31:0] wd);
    do @(negedge clk); while (!req_ready);
    req_valid = 1'b1; req_write = w; req_size = 2'(sz);
    req_bus = 8'(bus); req_devfn = 8'(devfn); req_offset = 8'(off); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R10 reset busy", 32'(busy), 0);
    chk(req_ready == 1'b1, "R10 reset ready", 32'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R10 reset rsp", 32'(rsp_valid), 0);
    chk(dn_req == 1'b0, "R1 reset dn_req", 32'(dn_req), 0);
    chk(err_sticky == 1'b0, "R9 reset err", 32'(err_sticky), 0);
    run = 1'b1;

    do_req(0, 2, 0, 8'h08, 8'h10, 0);                   // R4 word read, type 0
    for (int k = 0; k < 4; k++) do_req(0, 0, 0, 8'h10, 8'h3C + k, 0);   // R4 bytes
    do_req(0, 1, 0, 8'h10, 8'h04, 0);                   // R4 halves
    do_req(0, 1, 0, 8'h10, 8'h06, 0);
    do_req(0, 1, 0, 8'h10, 8'h07, 0);
    do_req(0, 2, 3, 8'h21, 8'h00, 0);                   // R2 type 1
    do_req(0, 0, 7, 8'h7F, 8'hFF, 0);                   // range edge, in range
    s_lat = 0;
    do_req(1, 2, 0, 8'h18, 8'h20, 32'hDEAD_BEEF);       // R6
    do_req(0, 2, 0, 8'h18, 8'h20, 0);
    s_lat = 3;
    do_req(1, 0, 0, 8'h18, 8'h21, 32'h0000_0055);       // R5 byte
    do_req(1, 0, 2, 8'h18, 8'h23, 32'h1234_56AA);
    do_req(1, 1, 0, 8'h18, 8'h22, 32'hCAFE_7788);       // R5 half
    do_req(1, 1, 0, 8'h18, 8'h24, 32'h0000_9911);
    do_req(0, 2, 0, 8'h18, 8'h20, 0);
    do_req(0, 1, 0, 8'h18, 8'h22, 0);
    s_lat = 1;
    do_req(0, 0, 8, 8'h00, 8'h00, 0);                   // R3
    do_req(0, 1, 0, 8'h80, 8'h04, 0);
    do_req(0, 2, 255, 8'hFF, 8'h08, 0);
    do_req(1, 3, 9, 8'h01, 8'h00, 32'h1111_2222);
    // request held during a busy transfer must be ignored (R10)
    s_lat = 5;
    do @(negedge clk); while (!req_ready);
    req_valid = 1'b1; req_write = 1'b0; req_size = 2'd2;
    req_bus = 8'd1; req_devfn = 8'h30; req_offset = 8'h0C;
    @(negedge clk);
    req_bus = 8'd9; req_devfn = 8'hFF;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    s_lat = 1;
    do_req(0, 2, 0, 8'h7E, 8'h00, 0);                   // R7 R8 default limit
    do_req(0, 2, 0, 8'h08, 8'h00, 0);                   // R9 stays set
    @(negedge clk); err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    @(negedge clk); tmo_load = 1'b1; tmo_value = 16'd8;
    @(negedge clk); tmo_load = 1'b0;
    do_req(1, 0, 0, 8'h7E, 8'h05, 32'h77);              // R7 timeout in read step
    do_req(0, 1, 0, 8'h7E, 8'h02, 0);
    @(negedge clk); err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    do_req(0, 0, 0, 8'h10, 8'h41, 0);
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule